// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

The block computes `base^exponent mod modulus` for operands of a configurable width `W`. It works entirely in the Montgomery residue domain. The caller supplies the exponent, an odd modulus, the base residue (`base * 2^W mod modulus`) and the residue of one (`2^W mod modulus`). Host software or another unit prepares these two residues.

A pulse on `start` while the engine is idle captures all operands. The engine then scans the exponent from bit `W-1` down to bit 0. For every bit it squares the accumulator, and when the bit is set it also multiplies the accumulator by the base residue. A final multiply by the constant one takes the value out of the Montgomery domain.

All products come from one bit-serial Montgomery multiplier inside the block. Each product takes `W` add-and-halve steps plus one cycle for the final conditional subtraction. `done` pulses when the plain result is on `result`, which then holds until the next run completes.

Top module: `montexp`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all 0.
- R2: For an odd modulus `m > 1`, a base residue below `m` and a one-residue equal to `2^W mod m`, `result` equals `base^exponent mod m` in ordinary (non-Montgomery) form.
- R3: An all-zero exponent yields `result = 1` (for `m > 1`).
- R4: Operands that use only a few low bits (zero-padded) and operands that fill nearly all `W` bits both give correct results; every exponent bit, including bit `W-1`, takes part.
- R5: `busy` is 1 for exactly `(W + popcount(exponent) + 1) * (W + 1)` cycles, starting in the cycle after `start` is sampled with `busy` low.
- R6: `done` is 1 for exactly one cycle, the first cycle with `busy` low after a run. `result` is valid in that cycle and holds its value until the next run ends.
- R7: `start` is ignored while `busy` is 1. The running computation, its length and its result are unaffected, even if the operand inputs change.
- R8: When `done` is 1, `result` is strictly less than the captured modulus.
- R9: A base residue of 0 yields 0. A base of `m-1` with an odd exponent yields `m-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| exp_in | input | W | Exponent |
| mod_in | input | W | Odd modulus |
| base_res | input | W | Base times 2^W mod modulus |
| one_res | input | W | 2^W mod modulus |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | W | base^exponent mod modulus |

## Verification
The bench targets operands that fill the whole width, which is where an undersized partial-sum register would wrap and give a large wrong value. It also uses a set exponent MSB, which a design that skipped bit `W-1` or stopped early would mishandle. An all-zero exponent would expose a missing closing conversion as `2^W mod m` instead of 1. An all-ones exponent stresses the latency count, so a miscounted multiply shows up as a wrong number of busy cycles. A second `start` is issued mid-run with different operands; a design that re-latched it would restart or return the wrong power.

// File: rtl/montexp.sv
module montexp #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] exp_in,
  input  logic [W-1:0] mod_in,
  input  logic [W-1:0] base_res,
  input  logic [W-1:0] one_res,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W + 1);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int SW = W + 2;

  typedef enum logic [1:0] {OP_SQ, OP_MUL, OP_CONV} op_t;

  logic [W-1:0]  e_q, m_q, b_q, x_q, y_q, res_q;
  logic [SW-1:0] s_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bidx_q;
  op_t           op_q;
  logic          busy_q, done_q;

  logic [SW-1:0] s_add, s_fix, s_step, s_red;
  logic [W-1:0]  prod;
  logic          mul_end, adv;

  assign s_add   = x_q[0] ? s_q + {2'b00, y_q} : s_q;
  assign s_fix   = s_add[0] ? s_add + {2'b00, m_q} : s_add;
  assign s_step  = s_fix >> 1;
  assign s_red   = (s_q >= {2'b00, m_q}) ? s_q - {2'b00, m_q} : s_q;
  assign prod    = s_red[W-1:0];
  assign mul_end = (cnt_q == CW'(W));
  assign adv     = (op_q == OP_MUL) || (op_q == OP_SQ && !e_q[bidx_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_q    <= '0;
      m_q    <= '0;
      b_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      res_q  <= '0;
      s_q    <= '0;
      cnt_q  <= '0;
      bidx_q <= '0;
      op_q   <= OP_SQ;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          e_q    <= exp_in;
          m_q    <= mod_in;
          b_q    <= base_res;
          x_q    <= one_res;
          y_q    <= one_res;
          s_q    <= '0;
          cnt_q  <= '0;
          bidx_q <= BW'(W - 1);
          op_q   <= OP_SQ;
          busy_q <= 1'b1;
        end
      end else if (!mul_end) begin
        s_q   <= s_step;
        x_q   <= x_q >> 1;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        s_q   <= '0;
        cnt_q <= '0;
        if (op_q == OP_CONV) begin
          res_q  <= prod;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else if (adv) begin
          if (bidx_q == '0) begin
            op_q <= OP_CONV;
            x_q  <= prod;
            y_q  <= W'(1);
          end else begin
            bidx_q <= bidx_q - 1'b1;
            op_q   <= OP_SQ;
            x_q    <= prod;
            y_q    <= prod;
          end
        end else begin
          op_q <= OP_MUL;
          x_q  <= b_q;
          y_q  <= prod;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/montexp_chk.sv
module montexp_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] m_q
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_fall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_start_begins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |=> $stable(result));

  assert_below_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < m_q));
endmodule

bind montexp montexp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .result(result), .m_q(m_q)
);

// File: tb/test_montexp.sv
module test_montexp;
  localparam int W = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 190000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] exp_in = '0, mod_in = '0, base_res = '0, one_res = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  int rem = 0;
  bit dexp = 0;
  bit have_res = 0;
  logic [W-1:0] exp_res = '0, pend_res = '0;
  string tag = "R2";

  montexp #(.W(W)) i_montexp (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in), .mod_in(mod_in),
    .base_res(base_res), .one_res(one_res), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] mulmod(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] m);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    return W'(p % {{W{1'b0}}, m});
  endfunction

  function automatic logic [W-1:0] powmod(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
    logic [W-1:0] a;
    a = W'(1) % m;
    for (int i = W - 1; i >= 0; i--) begin
      a = mulmod(a, a, m);
      if (e[i]) a = mulmod(a, b % m, m);
    end
    return a;
  endfunction

  function automatic logic [W-1:0] to_res(logic [W-1:0] v, logic [W-1:0] m);
    logic [2*W-1:0] t;
    t = {v, {W{1'b0}}};
    return W'(t % {{W{1'b0}}, m});
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      rem = 0;
      dexp = 0;
    end else begin
      dexp = 0;
      if (rem > 0) begin
        rem--;
        if (rem == 0) begin
          dexp = 1;
          exp_res = pend_res;
          have_res = 1;
        end
      end else if (start) begin
        rem = (W + $countones(exp_in) + 1) * (W + 1);
        pend_res = powmod(0, 0, 1);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (rem > 0), "R5 busy", W'(busy), W'(rem > 0));
      chk(done == dexp, "R6 done", W'(done), W'(dexp));
      if (done && dexp) chk(result == exp_res, tag, result, exp_res);
      else if (have_res && rem == 0) chk(result == exp_res, "R6 hold", result, exp_res);
    end
  end

  task automatic run(string t, logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
    @(negedge clk);
    tag = t;
    exp_in = e;
    mod_in = m;
    base_res = to_res(b, m);
    one_res = to_res(W'(1), m);
    start = 1'b1;
    @(posedge clk);
    #1;
    pend_res = powmod(b, e, m);
    @(negedge clk);
    start = 1'b0;
    while (rem > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", W'(busy), '0);
    chk(done == 1'b0, "R1 done", W'(done), '0);
    chk(result == '0, "R1 result", result, '0);
    rst_n = 1'b1;

    run("R4 small", W'(1570), W'(1019), W'(3337));
    run("R2 ref", W'(1570), W'(1019), W'(3337));
    run("R4 full", 64'hBE54_16AF_9696_937B, 64'h6F1E_6AB3_8667_7CDC, 64'hB4D9_2132_B032_10F7);
    run("R3 zero exp", W'(12345), '0, W'(3337));
    run("R4 msb exp", 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFC5);
    run("R5 ones exp", 64'h7777_1234_5678_9ABC, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF123_4567_89AB_CDEF);
    run("R9 zero base", '0, W'(77), 64'hD000_0000_0000_0001);
    run("R9 m-1 base", 64'hD000_0000_0000_0000, W'(77), 64'hD000_0000_0000_0001);
    run("R2 tiny mod", W'(2), W'(5), W'(3));

    // R7: a second start with other operands during a run is ignored
    @(negedge clk);
    tag = "R7 ignore start";
    exp_in = W'(1019); mod_in = W'(3337);
    base_res = to_res(W'(1570), W'(3337)); one_res = to_res(W'(1), W'(3337));
    start = 1'b1;
    @(posedge clk); #1;
    pend_res = powmod(W'(1570), W'(1019), W'(3337));
    @(negedge clk); start = 1'b0;
    repeat (200) @(negedge clk);
    exp_in = '1; mod_in = W'(101); base_res = W'(5); one_res = W'(7);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    exp_in = '0;
    while (rem > 0) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R7 idle after run", W'(busy), '0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule